// File: doc/BRIEF.md
# Latched One-of-Sixteen Line Decoder

This block turns a four-bit binary address into a single active line out of sixteen. The address first passes through a hold register: while the track input is high, the register loads the address on every rising clock edge. While track is low, the register keeps its value and changes on the address pins have no effect. The decoded line is then gated by an active-low enable, which acts at once and is never held.

A compile-time parameter selects the output polarity. In the active-high form, the chosen line is 1 and the idle level of every line is 0. In the active-low form, every bit is inverted, so the idle level is all ones. If a serial data signal drives the enable, the block works as a one-to-sixteen demultiplexer that steers the data to the addressed line. If the enable is used as a chip select, several decoders can share one address bus and together decode a wider address space.

Top module: `latched_line_decoder`

## Requirements
- R1: A synchronous reset, active high on `rst`, clears the held address to 0. After reset, with the enable active, line 0 is the selected line.
- R2: While `track_i` is 1 at a rising clock edge, the held address takes the value of `sel_i`. The outputs show the new address from that edge on.
- R3: While `track_i` is 0 at a rising clock edge, the held address keeps its value. Changes on `sel_i` leave `line_o` unchanged.
- R4: The address decodes in binary order. `sel_i[3]` is the most significant bit and `sel_i[0]` the least. Held address k selects `line_o[k]`, so 0 selects bit 0 and 15 selects bit 15.
- R5: When `en_n_i` is 1, no line is selected. All lines sit at the idle level: all zeros when `ACTIVE_LOW` = 0, all ones when `ACTIVE_LOW` = 1.
- R6: When `en_n_i` is 0, exactly one line differs from the idle level, and it is the addressed line. With `ACTIVE_LOW` = 0 that line is 1.
- R7: With `ACTIVE_LOW` = 1, `line_o` is the exact bitwise complement of the `ACTIVE_LOW` = 0 output for the same inputs and held address.
- R8: The enable is not held by the register. A change on `en_n_i` reaches `line_o` in the same cycle, whatever the value of `track_i`.
- R9: Used as a demultiplexer, a data stream on `en_n_i` with a fixed address appears on the addressed line only. With `ACTIVE_LOW` = 0 that line carries the inverse of the data, and every other line stays idle.
- R10: Two decoders on one address bus can be chip-selected by a fifth address bit. One is enabled when that bit is 0 and the other when it is 1. Together they assert exactly the one line out of 32 that the five-bit address names.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the address register samples on the rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the held address |
| track_i | input | 1 | 1: the register loads `sel_i` each edge; 0: the register holds |
| sel_i | input | ADDR_W (4) | Binary line address, bit 3 most significant |
| en_n_i | input | 1 | Active-low enable, chip select, or demultiplexer data input |
| line_o | output | 2**ADDR_W (16) | Decoded lines in the polarity chosen by `ACTIVE_LOW` |

## Verification
Two things can happen in the same cycle: the held address can move because `track_i` is high, and the enable can switch. The first shows at the outputs only after the clock edge; the second shows at once. The bench provokes this by toggling `en_n_i` in the same cycle that it presents a new address with tracking on. Before the edge it expects the old line, gated by the new enable. After the edge it expects the new line. Random stretches mix tracking, holding and enable changes, and each observation is judged against a model that updates the address only at the edge.

// File: rtl/lnd_pkg.sv
package lnd_pkg;
  // Idle value of one output line for a given polarity.
  function automatic logic idle_bit(input bit active_low);
    return active_low ? 1'b1 : 1'b0;
  endfunction

  // Whether line idx is the one named by addr.
  function automatic logic line_hit(input int unsigned addr, input int unsigned idx);
    return addr == idx;
  endfunction
endpackage

// File: rtl/lnd_addr_hold.sv
module lnd_addr_hold #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              track_i,
  input  logic [ADDR_W-1:0] sel_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk) begin
    if (rst)          addr_o <= '0;
    else if (track_i) addr_o <= sel_i;
  end
endmodule

// File: rtl/lnd_onehot.sv
module lnd_onehot #(
  parameter int ADDR_W = 4,
  parameter int LINES  = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [LINES-1:0]  hot_o
);
  import lnd_pkg::*;
  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign hot_o[g] = line_hit(int'(addr_i), g);
  end
endmodule

// File: rtl/lnd_out_stage.sv
module lnd_out_stage #(
  parameter int LINES      = 16,
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic [LINES-1:0] hot_i,
  input  logic             grant_i,
  output logic [LINES-1:0] line_o
);
  logic [LINES-1:0] gated;
  assign gated = hot_i & {LINES{grant_i}};
  if (ACTIVE_LOW) begin : g_low
    assign line_o = ~gated;
  end else begin : g_high
    assign line_o = gated;
  end
endmodule

// File: rtl/latched_line_decoder.sv
module latched_line_decoder #(
  parameter int ADDR_W     = 4,
  parameter bit ACTIVE_LOW = 1'b0,
  localparam int LINES     = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              track_i,
  input  logic [ADDR_W-1:0] sel_i,
  input  logic              en_n_i,
  output logic [LINES-1:0]  line_o
);
  // Named internal events, visible to the bound checker.
  logic [ADDR_W-1:0] addr_q;
  logic [LINES-1:0]  hot_vec;
  logic              grant;

  assign grant = ~en_n_i;

  lnd_addr_hold #(.ADDR_W(ADDR_W)) hold_i (
    .clk     (clk),
    .rst     (rst),
    .track_i (track_i),
    .sel_i   (sel_i),
    .addr_o  (addr_q)
  );

  lnd_onehot #(.ADDR_W(ADDR_W), .LINES(LINES)) dec_i (
    .addr_i (addr_q),
    .hot_o  (hot_vec)
  );

  lnd_out_stage #(.LINES(LINES), .ACTIVE_LOW(ACTIVE_LOW)) out_i (
    .hot_i   (hot_vec),
    .grant_i (grant),
    .line_o  (line_o)
  );
endmodule

// File: rtl/latched_line_decoder_chk.sv
module latched_line_decoder_chk #(
  parameter int ADDR_W     = 4,
  parameter bit ACTIVE_LOW = 1'b0,
  localparam int LINES     = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic              track_i,
  input logic [ADDR_W-1:0] sel_i,
  input logic              en_n_i,
  input logic [LINES-1:0]  line_o,
  input logic [ADDR_W-1:0] addr_q
);
  localparam logic [LINES-1:0] IDLE = ACTIVE_LOW ? {LINES{1'b1}} : {LINES{1'b0}};

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> addr_q == '0);

  // R2
  track_load_chk: assert property (@(posedge clk) disable iff (rst)
    track_i |=> addr_q == $past(sel_i));

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !track_i |=> $stable(addr_q));

  // R5
  idle_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    en_n_i |-> line_o == IDLE);

  // R6
  single_line_chk: assert property (@(posedge clk) disable iff (rst)
    !en_n_i |-> $countones(line_o ^ IDLE) == 1);

  // R4
  addressed_line_chk: assert property (@(posedge clk) disable iff (rst)
    !en_n_i |-> line_o[addr_q] != IDLE[0]);
endmodule

bind latched_line_decoder latched_line_decoder_chk #(
  .ADDR_W(ADDR_W), .ACTIVE_LOW(ACTIVE_LOW)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .track_i (track_i),
  .sel_i   (sel_i),
  .en_n_i  (en_n_i),
  .line_o  (line_o),
  .addr_q  (addr_q)
);

// File: tb/latched_line_decoder_tb_top.sv
module latched_line_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        track;
  logic [3:0]  sel;
  logic        ext_en_n;
  logic        a4;
  logic        en_lo_n, en_hi_n;
  logic [15:0] line_i, line_b, line_c;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;
  int model_addr = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cycles++;

  // Chip-select split on a fifth address bit (R10).
  assign en_lo_n = ext_en_n | a4;
  assign en_hi_n = ext_en_n | ~a4;

  latched_line_decoder #(.ADDR_W(4), .ACTIVE_LOW(1'b0)) dut_i (
    .clk(clk), .rst(rst), .track_i(track), .sel_i(sel), .en_n_i(en_lo_n), .line_o(line_i));
  latched_line_decoder #(.ADDR_W(4), .ACTIVE_LOW(1'b0)) dut_b (
    .clk(clk), .rst(rst), .track_i(track), .sel_i(sel), .en_n_i(en_hi_n), .line_o(line_b));
  latched_line_decoder #(.ADDR_W(4), .ACTIVE_LOW(1'b1)) dut_c (
    .clk(clk), .rst(rst), .track_i(track), .sel_i(sel), .en_n_i(en_lo_n), .line_o(line_c));

  // Expected active-high lines for a held address and enable.
  function automatic logic [15:0] want_high(input int addr, input logic en_n);
    return en_n ? 16'h0000 : (16'h0001 << addr);
  endfunction

  function automatic logic [31:0] want_wide(input int addr, input logic top, input logic en_n);
    return en_n ? 32'h0 : (32'h1 << (top ? addr + 16 : addr));
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (held addr %0d)", tag, act, exp, model_addr);
    end
  endtask

  // Drive at the falling edge, check before the next rising edge, then
  // move the model address at that rising edge.
  task automatic cycle(input string tag, input logic r, input logic t,
                       input logic [3:0] s, input logic e, input logic hi);
    @(negedge clk);
    rst = r; track = t; sel = s; ext_en_n = e; a4 = hi;
    #1;
    if (!r) begin
      cmp(tag, {16'h0, line_i}, {16'h0, want_high(model_addr, e | hi)});
      // R7 complement of the active-high form
      cmp("R7", {16'h0, line_c}, {16'h0, ~want_high(model_addr, e | hi)});
      // R10 cascade across two decoders
      cmp("R10", {line_b, line_i}, want_wide(model_addr, hi, e));
    end
    @(posedge clk);
    if (r) model_addr = 0;
    else if (t) model_addr = int'(s);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      if (cycles > 100000) begin
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    rst = 1; track = 0; sel = 4'h9; ext_en_n = 0; a4 = 0;
    repeat (3) cycle("R1", 1, 0, 4'h9, 0, 0);
    // R1 reset state: line 0 selected, sel ignored while holding
    cycle("R1", 0, 0, 4'h7, 0, 0);
    // R2 R4 walk every address with tracking on
    for (int k = 0; k < 16; k++) cycle("R2 R4", 0, 1, 4'(k), 0, 0);
    cycle("R4", 0, 0, 4'h0, 0, 0);
    // R3 hold: address pins churn, outputs must stay on line 15
    for (int k = 0; k < 8; k++) cycle("R3", 0, 0, 4'($urandom_range(0, 15)), 0, 0);
    // R5 enable off, with and without tracking
    cycle("R5", 0, 1, 4'h3, 1, 0);
    cycle("R5", 0, 0, 4'hA, 1, 0);
    cycle("R6", 0, 0, 4'hA, 0, 0);
    // R9 demultiplex a data pattern onto held line 3
    for (int k = 0; k < 12; k++) cycle("R9", 0, 0, 4'hC, logic'((12'b1011_0010_1110 >> k) & 1), 0);
    // R8 enable switches in the same cycle as an address load
    cycle("R8", 0, 1, 4'h5, 1, 0);
    cycle("R8", 0, 1, 4'hE, 0, 0);
    cycle("R8", 0, 0, 4'h1, 1, 0);
    cycle("R8", 0, 0, 4'h1, 0, 0);
    // R10 both halves of the wide address space
    cycle("R10", 0, 1, 4'h6, 0, 1);
    cycle("R10", 0, 0, 4'h6, 0, 1);
    cycle("R10", 0, 0, 4'h6, 0, 0);
    // Random mix R2/R3/R5/R6, with a mid-run reset for R1
    for (int k = 0; k < 400; k++) begin
      logic r;
      r = ($urandom_range(0, 99) == 0);
      cycle("R2/R3/R5/R6", r, logic'($urandom_range(0, 1)), 4'($urandom_range(0, 15)),
            ($urandom_range(0, 3) == 0), logic'($urandom_range(0, 1)));
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule